// File: doc/BRIEF.md
# Extended Flat ROM Address Decoder

This block sits on the cartridge side of an 8-bit CPU bus with a 16-bit address and a read/write strobe. It lets one 64 KiB program ROM show up as two regions. The first is the usual 32 KiB at the top of memory. The second is a contiguous 14 KiB window directly beneath it. There are no bank registers and no writable state. The mapping is fixed and purely combinational.

The ROM offset is the CPU address with its most significant bit flipped. The lower half of CPU space therefore folds onto the upper half of the ROM. An unsigned threshold compare keeps the ROM deselected below the window floor. That keeps the lower part of the folded half off the bus, along with everything below it. ROM offsets from 0x8000 through 0xC7FF are padding that the CPU never reaches.

The output enable follows only the bus phase and the read strobe. Decode glitches of a few gate delays are harmless at the roughly 2 MHz bus rate.

There are no data streams here, so every pin is a plain level signal with no handshake.

Top module: `xrom_decoder`

## Requirements
- R1: `rom_addr` equals `cpu_addr` with bit 15 inverted and bits 14 to 0 unchanged, for every CPU address.
- R2: For CPU addresses 0x8000 to 0xFFFF, `rom_ce_n` is 0 and the ROM offset lies in 0x0000 to 0x7FFF.
- R3: For CPU addresses 0x4800 to 0x7FFF, `rom_ce_n` is 0 and the ROM offset lies in 0xC800 to 0xFFFF.
- R4: For CPU addresses 0x4000 to 0x47FF, `rom_ce_n` is 1.
- R5: For CPU addresses 0x0000 to 0x3FFF, `rom_ce_n` is 1.
- R6: `rom_oe_n` is 0 exactly when `cpu_rw` is 1 (read) and `bus_phi` is 1. Otherwise it is 1, whatever the address.
- R7: While `rom_ce_n` is 0, `rom_addr` never lies in the padding range 0x8000 to 0xC7FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_phi | input | 1 | Bus-phase clock; data phase while high |
| rom_addr | output | 16 | ROM address lines |
| rom_ce_n | output | 1 | Active-low ROM chip enable |
| rom_oe_n | output | 1 | Active-low ROM output enable |

## Verification
The block holds no state, so any fault shows at the ports in the same bus cycle as the address that exercises it.

The sweep reaches every CPU address, so faults are caught wherever they sit:
- A mis-set threshold shows up as a wrong enable at the window edges 0x47FF/0x4800 or 0x3FFF/0x4000.
- A flipped or dropped address line shows up as a wrong offset on half or more of the space.

The read-gate combinations are driven on addresses in each region. This catches an output enable that leaks through on writes or outside the data phase.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned MSB       = ADDR_W - 1;
  localparam logic [MSB:0] TOP_HALF = {1'b1, {MSB{1'b0}}};
  localparam logic [MSB:0] WIN_LO   = 16'h4800;
  localparam logic [MSB:0] PAD_LO   = 16'h8000;
  localparam logic [MSB:0] PAD_HI   = 16'hC7FF;
endpackage

// File: rtl/xrom_fold.sv
module xrom_fold #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] cpu_a,
  output logic [AW-1:0] rom_a
);
  localparam int unsigned LOW_W = AW - 1;
  logic [LOW_W-1:0] low_pass;

  assign low_pass = cpu_a[LOW_W-1:0];
  assign rom_a    = {~cpu_a[AW-1], low_pass};

  always_comb begin
    a_lowbits_r1: assert (rom_a[LOW_W-1:0] == cpu_a[LOW_W-1:0])
      else $error("R1 low address bits altered");
  end
endmodule

// File: rtl/xrom_window_cmp.sv
module xrom_window_cmp #(
  parameter int unsigned AW      = 16,
  parameter logic [AW-1:0] FLOOR = 16'h4800,
  parameter bit USE_SUB          = 1'b0
) (
  input  logic [AW-1:0] a,
  output logic          at_or_above
);
  generate
    if (USE_SUB) begin : g_sub
      logic [AW:0] diff;
      assign diff        = {1'b0, a} - {1'b0, FLOOR};
      assign at_or_above = ~diff[AW];
    end else begin : g_cmp
      assign at_or_above = (a >= FLOOR);
    end
  endgenerate
endmodule

// File: rtl/xrom_read_gate.sv
module xrom_read_gate (
  input  logic rw,
  input  logic phi,
  output logic oe_n
);
  logic read_phase;
  assign read_phase = rw & phi;
  assign oe_n       = ~read_phase;
endmodule

// File: rtl/xrom_decoder.sv
module xrom_decoder
  import xrom_pkg::*;
#(
  parameter bit CMP_SUB = 1'b0
) (
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rw,
  input  logic        bus_phi,
  output logic [15:0] rom_addr,
  output logic        rom_ce_n,
  output logic        rom_oe_n
);
  logic in_window;

  xrom_fold #(.AW(ADDR_W)) u_fold (
    .cpu_a (cpu_addr),
    .rom_a (rom_addr)
  );

  xrom_window_cmp #(.AW(ADDR_W), .FLOOR(WIN_LO), .USE_SUB(CMP_SUB)) u_cmp (
    .a           (cpu_addr),
    .at_or_above (in_window)
  );

  xrom_read_gate u_gate (
    .rw   (cpu_rw),
    .phi  (bus_phi),
    .oe_n (rom_oe_n)
  );

  assign rom_ce_n = ~in_window;

  always_comb begin
    if (!rom_ce_n)
      a_no_pad_r7: assert (!(rom_addr >= PAD_LO && rom_addr <= PAD_HI))
        else $error("R7 padding offset selected");
    if (cpu_addr[MSB])
      a_top_r2: assert (!rom_ce_n && !rom_addr[MSB])
        else $error("R2 top half mis-mapped");
    if (cpu_addr < 16'h4000)
      a_low_off_r5: assert (rom_ce_n)
        else $error("R5 low region enabled ROM");
    if (!cpu_rw)
      a_wr_quiet_r6: assert (rom_oe_n)
        else $error("R6 output enabled on write");
  end
endmodule

// File: tb/xrom_decoder_test.sv
module xrom_decoder_test;
  typedef struct {
    logic [15:0] addr;
    logic [15:0] exp_rom;
    logic        exp_ce_n;
    logic        exp_oe_n;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic cpu_rw = 1'b0;
  logic bus_phi = 1'b0;
  logic [15:0] rom_addr;
  logic rom_ce_n, rom_oe_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t q[$];

  always #10 clk = ~clk;

  xrom_decoder uut (
    .cpu_addr (cpu_addr),
    .cpu_rw   (cpu_rw),
    .bus_phi  (bus_phi),
    .rom_addr (rom_addr),
    .rom_ce_n (rom_ce_n),
    .rom_oe_n (rom_oe_n)
  );

  function automatic string region(input logic [15:0] a);
    if (a >= 16'h8000) return "R2";
    if (a >= 16'h4800) return "R3";
    if (a >= 16'h4000) return "R4";
    return "R5";
  endfunction

  task automatic drive(input logic [15:0] a, input logic rw, input logic phi,
                       input string tag);
    item_t it;
    @(negedge clk);
    cpu_addr = a;
    cpu_rw   = rw;
    bus_phi  = phi;
    it.addr     = a;
    it.exp_rom  = a ^ 16'h8000;
    it.exp_ce_n = (a < 16'h4800);
    it.exp_oe_n = !(rw && phi);
    it.req      = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rom_addr !== it.exp_rom) begin
        errors++;
        $display("FAIL R1 (%s) addr %h rom_addr %h expected %h", it.req, it.addr, rom_addr, it.exp_rom);
      end else if (rom_ce_n !== it.exp_ce_n) begin
        errors++;
        $display("FAIL %s addr %h ce_n %b expected %b", it.req, it.addr, rom_ce_n, it.exp_ce_n);
      end else if (rom_oe_n !== it.exp_oe_n) begin
        errors++;
        $display("FAIL R6 (%s) addr %h oe_n %b expected %b", it.req, it.addr, rom_oe_n, it.exp_oe_n);
      end else if (!rom_ce_n && rom_addr >= 16'h8000 && rom_addr <= 16'hC7FF) begin
        errors++;
        $display("FAIL R7 addr %h rom_addr %h expected outside 8000-C7FF", it.addr, rom_addr);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset state: address 0, write, phase low -> ROM off (R5, R6)
    drive(16'h0000, 1'b0, 1'b0, "R5");
    // Full sweep as reads in data phase (R1..R5, R7)
    for (int i = 0; i < 65536; i++) drive(16'(i), 1'b1, 1'b1, region(16'(i)));
    // Boundary addresses again (R3 floor, R4 ceiling, R5 edge)
    drive(16'h47FF, 1'b1, 1'b1, "R4");
    drive(16'h4800, 1'b1, 1'b1, "R3");
    drive(16'h3FFF, 1'b1, 1'b1, "R5");
    drive(16'h4000, 1'b1, 1'b1, "R4");
    drive(16'h7FFF, 1'b1, 1'b1, "R3");
    drive(16'h8000, 1'b1, 1'b1, "R2");
    // Read gate combinations in every region (R6)
    foreach (q[k]) begin end
    for (int r = 0; r < 4; r++) begin
      logic [15:0] a;
      a = (r == 0) ? 16'h1234 : (r == 1) ? 16'h4400 : (r == 2) ? 16'h5A5A : 16'hC3C3;
      drive(a, 1'b0, 1'b0, "R6");
      drive(a, 1'b0, 1'b1, "R6");
      drive(a, 1'b1, 1'b0, "R6");
      drive(a, 1'b1, 1'b1, "R6");
    end
    repeat (4) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule